// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the clock-enable pin during power-down. The controller pulses an entry request when it wants the memory to drop into its low-power state. The sequencer waits until no read or write burst is in flight, including its postamble, and then drives CKE low. It records whether any bank had an open row at that moment, which makes the mode either active power-down or precharge power-down.

A wake pulse brings the memory back out. CKE is raised together with a forced NOP on the command bus. The general command-ready flag returns one clock later. If the DLL was switched off for the low-power period, the sequencer turns it back on at exit. It then keeps a separate read-ready flag low for a fixed lockout, while all other commands are allowed through.

Top module: `sdram_pd_seq`

## Requirements
- R1: After reset, cke, dll_en, cmd_ready and read_ready are 1, and nop_strobe and pd_active are 0.
- R2: When pd_req is high, or an entry is pending, and burst_busy is low at a clock edge in the running state, cke is 0 and pd_active is 1 after that edge. cke never falls at an edge where burst_busy is high.
- R3: A pd_req pulse that arrives while burst_busy is high is remembered. cke falls at the first edge at which burst_busy is sampled low.
- R4: pd_mode_act takes the OR of bank_open at the entry edge (1 = active power-down, 0 = precharge power-down) and holds it for the whole low-power period.
- R5: While in power-down, cke stays 0, cmd_ready is 0 and nop_strobe is 1. burst_busy, pd_req and bank_open have no effect there.
- R6: cke stays 0 for at least two cycles. A wake_req that arrives during the first cycle with cke low is held and serviced at the following edge. From then on, wake_req raises cke at the edge where it is sampled.
- R7: In the cycle in which cke is first high again, nop_strobe is 1 and cmd_ready is 0. cmd_ready returns to 1 one cycle later.
- R8: If dll_off_req is 1 at the entry edge, dll_en is 0 throughout power-down and returns to 1 at the exit edge. Otherwise dll_en stays 1.
- R9: After an exit with the DLL off, read_ready first reads 1 exactly DLL_LOCK_CYCLES cycles after cke is first high, and read_ready never reads 1 while cmd_ready is 0.
- R10: wake_req has no effect while the memory is not in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Pulse asking for power-down entry |
| wake_req | input | 1 | Pulse asking for power-down exit |
| burst_busy | input | 1 | High from READ/WRITE issue through postamble |
| bank_open | input | NUM_BANKS | One bit per bank, 1 = row open |
| dll_off_req | input | 1 | Turn the DLL off for this power-down |
| cke | output | 1 | Clock enable to the memory |
| nop_strobe | output | 1 | Forces NOP/DESELECT on the command bus |
| pd_active | output | 1 | Memory is in power-down |
| pd_mode_act | output | 1 | 1 = active power-down, 0 = precharge power-down |
| dll_en | output | 1 | DLL enable to the memory |
| cmd_ready | output | 1 | Non-READ commands may be issued |
| read_ready | output | 1 | READ commands may be issued |

## Verification
The bench holds an entry request across a long busy burst. A design that drops the request, or drops CKE mid-burst, shows up as a CKE mismatch. A wake pulse is placed inside the very first low cycle: a design that ignores it stays in power-down forever, and one that exits at once gives a single-cycle CKE low. The DLL lockout is counted edge by edge from the CKE rise, so an off-by-one counter or a lockout that also blocks non-READ commands is caught. Bank activity and stray requests are changed during power-down and while running, to expose a mode flag that follows the live inputs and wake pulses that leak outside power-down.

// File: rtl/sdram_pd_seq.sv
module sdram_pd_seq #(
  parameter int NUM_BANKS       = 4,
  parameter int DLL_LOCK_CYCLES = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_req,
  input  logic                 wake_req,
  input  logic                 burst_busy,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 dll_off_req,
  output logic                 cke,
  output logic                 nop_strobe,
  output logic                 pd_active,
  output logic                 pd_mode_act,
  output logic                 dll_en,
  output logic                 cmd_ready,
  output logic                 read_ready
);
  localparam int LOCK_W = $clog2(DLL_LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_INIT = LOCK_W'(DLL_LOCK_CYCLES);

  typedef enum logic [1:0] {ST_RUN, ST_PD, ST_EXIT} st_t;

  st_t              st_q;
  logic             enter_pend_q, wake_pend_q, seen_low_q;
  logic [LOCK_W-1:0] lock_q;

  assign cmd_ready  = (st_q == ST_RUN);
  assign nop_strobe = ~cmd_ready;
  assign pd_active  = (st_q == ST_PD);
  assign read_ready = cmd_ready && (lock_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      cke          <= 1'b1;
      dll_en       <= 1'b1;
      pd_mode_act  <= 1'b0;
      enter_pend_q <= 1'b0;
      wake_pend_q  <= 1'b0;
      seen_low_q   <= 1'b0;
      lock_q       <= '0;
    end else begin
      if (lock_q != '0) lock_q <= lock_q - LOCK_W'(1);
      case (st_q)
        ST_RUN: begin
          if ((enter_pend_q || pd_req) && !burst_busy) begin
            st_q         <= ST_PD;
            cke          <= 1'b0;
            pd_mode_act  <= |bank_open;
            dll_en       <= ~dll_off_req;
            enter_pend_q <= 1'b0;
            wake_pend_q  <= 1'b0;
            seen_low_q   <= 1'b0;
          end else if (pd_req) begin
            enter_pend_q <= 1'b1;
          end
        end
        ST_PD: begin
          seen_low_q <= 1'b1;
          if (seen_low_q && (wake_req || wake_pend_q)) begin
            st_q   <= ST_EXIT;
            cke    <= 1'b1;
            dll_en <= 1'b1;
            if (!dll_en) lock_q <= LOCK_INIT;
          end else if (wake_req) begin
            wake_pend_q <= 1'b1;
          end
        end
        default: begin
          st_q <= ST_RUN;
          if (pd_req) enter_pend_q <= 1'b1;
        end
      endcase
    end
  end

  // R2
  busy_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_busy && cke) |=> cke);

  // R6
  min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> !cke);

  // R7
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (nop_strobe && !cmd_ready));

  // R7
  exit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> cmd_ready);

  // R5
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (!cke && nop_strobe));

  // R4
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && $past(pd_active)) |-> $stable(pd_mode_act));

  // R8
  dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dll_en |-> !cke);

  // R9
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_ready |-> cmd_ready);
endmodule

// File: tb/sdram_pd_seq_tb.sv
module sdram_pd_seq_tb_top;
  localparam int NB   = 4;
  localparam int LOCK = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, wake_req = 0, burst_busy = 0, dll_off_req = 0;
  logic [NB-1:0] bank_open = '0;
  logic cke, nop_strobe, pd_active, pd_mode_act, dll_en, cmd_ready, read_ready;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_pd_seq #(.NUM_BANKS(NB), .DLL_LOCK_CYCLES(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
    .burst_busy(burst_busy), .bank_open(bank_open), .dll_off_req(dll_off_req),
    .cke(cke), .nop_strobe(nop_strobe), .pd_active(pd_active),
    .pd_mode_act(pd_mode_act), .dll_en(dll_en), .cmd_ready(cmd_ready),
    .read_ready(read_ready));

  // behavioural reference
  bit m_pd, m_exit, m_pend, m_wp, m_mode, m_dll;
  int m_low, m_lock;

  always @(posedge clk) begin
    int nl;
    if (!rst_n) begin
      m_pd = 0; m_exit = 0; m_pend = 0; m_wp = 0; m_mode = 0; m_dll = 1;
      m_low = 0; m_lock = 0;
    end else begin
      nl = (m_lock > 0) ? m_lock - 1 : 0;
      if (m_exit) begin
        m_exit = 0;
        if (pd_req) m_pend = 1;
      end else if (!m_pd) begin
        if ((m_pend || pd_req) && !burst_busy) begin
          m_pd = 1; m_low = 0; m_mode = (bank_open != 0); m_dll = !dll_off_req;
          m_pend = 0; m_wp = 0;
        end else if (pd_req) m_pend = 1;
      end else begin
        if (m_low >= 1 && (wake_req || m_wp)) begin
          m_pd = 0; m_exit = 1;
          if (!m_dll) nl = LOCK;
          m_dll = 1;
        end else if (wake_req) m_wp = 1;
        m_low++;
      end
      m_lock = nl;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit cr;
    if (rst_n && !done) begin
      cr = !m_pd && !m_exit;
      chk("R2 cke", cke, !m_pd);
      chk("R5 pd_active", pd_active, m_pd);
      chk("R7 cmd_ready", cmd_ready, cr);
      chk("R7 nop_strobe", nop_strobe, !cr);
      chk("R8 dll_en", dll_en, m_dll);
      chk("R9 read_ready", read_ready, cr && m_lock == 0);
      if (m_pd) chk("R4 pd_mode_act", pd_mode_act, m_mode);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pd();
    pd_req = 1; tick(1); pd_req = 0;
  endtask

  task automatic pulse_wake();
    wake_req = 1; tick(1); wake_req = 0;
  endtask

  initial begin
    int k;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    chk("R1 cke", cke, 1); chk("R1 dll_en", dll_en, 1);
    chk("R1 cmd_ready", cmd_ready, 1); chk("R1 read_ready", read_ready, 1);
    chk("R1 nop_strobe", nop_strobe, 0); chk("R1 pd_active", pd_active, 0);

    // R10: wake while running does nothing
    pulse_wake(); tick(2);
    chk("R10 cke", cke, 1); chk("R10 cmd_ready", cmd_ready, 1);

    // R2: plain entry, precharge mode
    pulse_pd();
    chk("R2 cke low", cke, 0); chk("R4 precharge mode", pd_mode_act, 0);
    tick(4); pulse_wake(); tick(3);

    // R3: request held across busy
    burst_busy = 1; pulse_pd(); tick(5);
    chk("R3 cke held high", cke, 1);
    burst_busy = 0; tick(1);
    chk("R3 cke after busy", cke, 0);
    // R4/R5: bank change and noise during power-down
    bank_open = 4'b0100; burst_busy = 1; pulse_pd(); tick(2);
    chk("R4 mode latched", pd_mode_act, 0); chk("R5 still low", cke, 0);
    burst_busy = 0; pulse_wake(); tick(3);

    // R4: active mode
    bank_open = 4'b0100; pulse_pd(); bank_open = '0;
    chk("R4 active mode", pd_mode_act, 1);
    tick(3); pulse_wake(); tick(3);

    // R6: wake in the first low cycle
    pd_req = 1; tick(1); pd_req = 0;
    wake_req = 1; tick(1); wake_req = 0;
    chk("R6 still low", cke, 0);
    tick(1);
    chk("R6 woke", cke, 1); chk("R7 nop on exit", nop_strobe, 1);
    tick(1);
    chk("R7 cmd_ready back", cmd_ready, 1);
    tick(2);

    // R8/R9: DLL off lockout
    dll_off_req = 1; pulse_pd(); dll_off_req = 0;
    chk("R8 dll off", dll_en, 0);
    tick(3); wake_req = 1;
    k = 0;
    while (cke == 0 && k < 10) begin tick(1); k++; end
    wake_req = 0;
    chk("R8 dll on", dll_en, 1);
    k = 0;
    while (read_ready == 0 && k < LOCK + 20) begin tick(1); k++; end
    chk("R9 lockout length", k, LOCK);
    tick(3);

    // mixed random traffic checked by the reference
    for (int i = 0; i < 6000; i++) begin
      pd_req = ($urandom_range(0, 15) == 0);
      wake_req = ($urandom_range(0, 7) == 0);
      burst_busy = ($urandom_range(0, 3) == 0);
      dll_off_req = ($urandom_range(0, 3) == 0);
      bank_open = NB'($urandom);
      tick(1);
    end
    pd_req = 0; wake_req = 0; burst_busy = 0;
    tick(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule